// File: doc/BRIEF.md
# Host-to-DSP Mailbox Register Block

This block carries short 16-bit messages between a host processor and a signal-processing core. It has three command channels, running from the host to the DSP, and three reply channels, running from the DSP to the host. Each channel holds exactly one word. A flag records whether that word is still waiting for the other side.

The host reaches the block through a simple register port with strobed reads and writes. The register port contains:

- a 16-bit configuration register;
- a read-only status word that gathers every channel flag;
- the command registers and the reply registers.

The register window is mirrored every 64 bytes. The DSP side sees each command word together with its pending flag, and can pop it. The DSP side pushes replies with a strobe and a data word. A reply arriving on channel n can raise a one-cycle interrupt pulse toward the host, if configuration bit 9+n enables it.

Read data is combinational and valid in the same cycle as `hst_rd`. A read of a reply register consumes the word at the clock edge that ends the read cycle.

Top module: `mbox_top`

## Requirements
- R1: After reset, every command register, reply register, the configuration register and the status word read 0, no command is pending, and `irq` is low.
- R2: Only address bits [5:1] are decoded, so the map repeats every 0x40 bytes and bit 0 is ignored. The map is:
  - configuration at 0x08;
  - status at 0x0C;
  - commands at 0x20, 0x28 and 0x30;
  - replies at 0x24, 0x2C and 0x34.
  Any other offset reads 0.
- R3: A host write to command register n stores the word, presents it on slice n of `dsp_cmd_data` from the next cycle, and sets `dsp_cmd_pending[n]`. A host read of the command register returns the last value written.
- R4: A DSP pop of channel n clears its pending flag and leaves the word unchanged. A pop in the same cycle as a host write to that channel leaves the flag set. A pop of an empty channel has no effect.
- R5: Status bit 13+n equals the pending flag of command channel n.
- R6: A DSP push on reply channel n stores the word and sets the ready flag. Status bit 10+n equals that ready flag. Status bits 0 to 9 always read 0.
- R7: A host read of reply register n returns the stored word and clears the ready flag. If a push to the same channel happens in that cycle, the read returns the old word and the flag stays set with the new word.
- R8: A push to a reply channel that is already ready overwrites the word and keeps the ready flag set.
- R9: `irq` is high for exactly the one cycle after any cycle in which a reply push occurs on a channel whose configuration bit 9+n was set. Otherwise it is low.
- R10: Host writes to reply registers, the status word or unmapped offsets change nothing.
- R11: The configuration register is 16 bits wide, fully writable, and reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 8 | Host byte address (low 6 bits decoded) |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (consumes replies) |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, combinational |
| irq | output | 1 | One-cycle reply interrupt pulse |
| dsp_cmd_data | output | 48 | Command words, channel n at bits 16n+15:16n |
| dsp_cmd_pending | output | 3 | Command word waiting, one bit per channel |
| dsp_cmd_pop | input | 3 | DSP takes command, one bit per channel |
| dsp_rep_push | input | 3 | DSP delivers reply, one bit per channel |
| dsp_rep_data | input | 48 | Reply words, channel n at bits 16n+15:16n |

## Verification
The assertions check on every cycle that:
- each command write sets the pending flag with the written word;
- a lone pop clears the pending flag;
- a push sets the ready flag and loads its word;
- a lone host read of a reply clears its flag;
- the address decode never selects two registers at once;
- `irq` follows exactly the enabled pushes of the previous cycle.

Only the bench's scenarios can show the rest:
- what the host actually reads back through the mirrored map;
- the composed status word after mixed sequences;
- that writes to read-only offsets leave all state untouched;
- the tie-breaks when a host access and a DSP strobe hit one channel in the same cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // byte offsets inside the 64-byte register window
    localparam logic [5:0] OFF_CFG   = 6'h08;
    localparam logic [5:0] OFF_STAT  = 6'h0C;
    localparam logic [5:0] OFF_CMD0  = 6'h20;
    localparam logic [5:0] OFF_REP0  = 6'h24;
    localparam int         CH_STRIDE = 8;

    // bit positions inside status and configuration
    localparam int STAT_REP_LSB = 10;
    localparam int STAT_CMD_LSB = 13;
    localparam int CFG_IRQ_LSB  = 9;

    function automatic logic [5:0] cmd_off(input int ch);
        return 6'(int'(OFF_CMD0) + CH_STRIDE * ch);
    endfunction

    function automatic logic [5:0] rep_off(input int ch);
        return 6'(int'(OFF_REP0) + CH_STRIDE * ch);
    endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [5:1]        addr_hw,
    output logic              cfg_hit,
    output logic              stat_hit,
    output logic [NUM_CH-1:0] cmd_hit,
    output logic [NUM_CH-1:0] rep_hit
);

    assign cfg_hit  = (addr_hw == OFF_CFG[5:1]);
    assign stat_hit = (addr_hw == OFF_STAT[5:1]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [5:0] CMD_OFF = cmd_off(i);
        localparam logic [5:0] REP_OFF = rep_off(i);
        assign cmd_hit[i] = (addr_hw == CMD_OFF[5:1]);
        assign rep_hit[i] = (addr_hw == REP_OFF[5:1]);
    end

endmodule

// File: rtl/mbox_cmd_slot.sv
module mbox_cmd_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] data,
    output logic              pending
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              pend;
    } cmd_state_t;

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = wdata;
            st_d.pend = 1'b1;
        end else if (pop) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data    = st_q.word;
    assign pending = st_q.pend;

    p_wr_sets_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pending && data == $past(wdata)));

    p_pop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !wr_en) |=> !pending);

    p_word_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(data));

endmodule

// File: rtl/mbox_rep_slot.sv
module mbox_rep_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              ready
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              rdy;
    } rep_state_t;

    rep_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.word = push_data;
            st_d.rdy  = 1'b1;
        end else if (take) begin
            st_d.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data  = st_q.word;
    assign ready = st_q.rdy;

    p_push_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (ready && data == $past(push_data)));

    p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !push) |=> !ready);

    p_ready_from_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(push));

endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int DATA_W  = 16,
    parameter int HADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [HADDR_W-1:0]       hst_addr,
    input  logic                     hst_wr,
    input  logic                     hst_rd,
    input  logic [DATA_W-1:0]        hst_wdata,
    output logic [DATA_W-1:0]        hst_rdata,
    output logic                     irq,
    output logic [NUM_CH*DATA_W-1:0] dsp_cmd_data,
    output logic [NUM_CH-1:0]        dsp_cmd_pending,
    input  logic [NUM_CH-1:0]        dsp_cmd_pop,
    input  logic [NUM_CH-1:0]        dsp_rep_push,
    input  logic [NUM_CH*DATA_W-1:0] dsp_rep_data
);

    localparam int DW = DATA_W;

    // outside the decoded window: the map mirrors
    logic unused_addr_bits;
    assign unused_addr_bits = ^{hst_addr[HADDR_W-1:6], hst_addr[0]};

    logic              cfg_hit, stat_hit;
    logic [NUM_CH-1:0] cmd_hit, rep_hit;

    mbox_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr_hw (hst_addr[5:1]),
        .cfg_hit (cfg_hit),
        .stat_hit(stat_hit),
        .cmd_hit (cmd_hit),
        .rep_hit (rep_hit)
    );

    logic [NUM_CH-1:0]    rep_ready;
    logic [DW-1:0]        rep_word [NUM_CH];
    logic [DW-1:0]        cmd_word [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        mbox_cmd_slot #(.DATA_W(DW)) u_cmd (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (hst_wr && cmd_hit[i]),
            .wdata  (hst_wdata),
            .pop    (dsp_cmd_pop[i]),
            .data   (cmd_word[i]),
            .pending(dsp_cmd_pending[i])
        );

        mbox_rep_slot #(.DATA_W(DW)) u_rep (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (dsp_rep_push[i]),
            .push_data(dsp_rep_data[i*DW +: DW]),
            .take     (hst_rd && rep_hit[i]),
            .data     (rep_word[i]),
            .ready    (rep_ready[i])
        );

        assign dsp_cmd_data[i*DW +: DW] = cmd_word[i];
    end

    typedef struct packed {
        logic [DW-1:0] cfg;
        logic          irq;
    } top_state_t;

    top_state_t st_d, st_q;
    logic [NUM_CH-1:0] irq_en;

    assign irq_en = st_q.cfg[CFG_IRQ_LSB +: NUM_CH];

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(dsp_rep_push & irq_en);
        if (hst_wr && cfg_hit) st_d.cfg = hst_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    logic [DW-1:0] status;
    always_comb begin
        status = '0;
        status[STAT_REP_LSB +: NUM_CH] = rep_ready;
        status[STAT_CMD_LSB +: NUM_CH] = dsp_cmd_pending;
    end

    always_comb begin
        hst_rdata = '0;
        if (cfg_hit)  hst_rdata = st_q.cfg;
        if (stat_hit) hst_rdata = status;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cmd_hit[i]) hst_rdata = cmd_word[i];
            if (rep_hit[i]) hst_rdata = rep_word[i];
        end
    end

    p_decode_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_hit, stat_hit, cmd_hit, rep_hit}));

    p_irq_follows_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dsp_rep_push & irq_en)) |=> irq);

    p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(dsp_rep_push & irq_en)));

    p_cfg_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && cfg_hit) |=> (st_q.cfg == $past(hst_wdata)));

endmodule

// File: tb/mbox_top_tb.sv
module mbox_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  hst_addr;
    logic        hst_wr, hst_rd;
    logic [15:0] hst_wdata, hst_rdata;
    logic        irq;
    logic [47:0] dsp_cmd_data;
    logic [2:0]  dsp_cmd_pending, dsp_cmd_pop, dsp_rep_push;
    logic [47:0] dsp_rep_data;

    always #2 clk = ~clk;

    mbox_top u_dut (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
        .hst_rd(hst_rd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .irq(irq), .dsp_cmd_data(dsp_cmd_data),
        .dsp_cmd_pending(dsp_cmd_pending), .dsp_cmd_pop(dsp_cmd_pop),
        .dsp_rep_push(dsp_rep_push), .dsp_rep_data(dsp_rep_data)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [15:0] m_cmd [3];
    logic [15:0] m_rep [3];
    logic [2:0]  m_pend;
    logic [2:0]  m_rdy;
    logic [15:0] m_cfg;
    logic        m_irq;

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        int off;
        off = int'(a[5:0]) & 'h3E;
        if (off == 'h08) return m_cfg;
        if (off == 'h0C) return {m_pend, m_rdy, 10'b0};
        for (int n = 0; n < 3; n++) begin
            if (off == 'h20 + 8 * n) return m_cmd[n];
            if (off == 'h24 + 8 * n) return m_rep[n];
        end
        return 16'h0;
    endfunction

    task automatic step(input string tag, input logic w, input logic r,
                        input logic [7:0] a, input logic [15:0] d,
                        input logic [2:0] pp, input logic [2:0] ps,
                        input logic [47:0] pd);
        int off;
        hst_wr = w; hst_rd = r; hst_addr = a; hst_wdata = d;
        dsp_cmd_pop = pp; dsp_rep_push = ps; dsp_rep_data = pd;
        #1;
        if (r) chk(tag, 48'(hst_rdata), 48'(exp_read(a)));
        chk("R5 pending flags", 48'(dsp_cmd_pending), 48'(m_pend));
        chk("R3 command words", dsp_cmd_data, {m_cmd[2], m_cmd[1], m_cmd[0]});
        chk("R9 irq", 48'(irq), 48'(m_irq));
        @(posedge clk);
        off = int'(a[5:0]) & 'h3E;
        m_irq = |(ps & m_cfg[11:9]);
        for (int n = 0; n < 3; n++) begin
            if (w && off == 'h20 + 8 * n) begin
                m_cmd[n] = d; m_pend[n] = 1'b1;
            end else if (pp[n]) begin
                m_pend[n] = 1'b0;
            end
            if (ps[n]) begin
                m_rep[n] = pd[16*n +: 16]; m_rdy[n] = 1'b1;
            end else if (r && off == 'h24 + 8 * n) begin
                m_rdy[n] = 1'b0;
            end
        end
        if (w && off == 'h08) m_cfg = d;
        @(negedge clk);
    endtask

    task automatic hw(input logic [7:0] a, input logic [15:0] d);
        step("host write", 1'b1, 1'b0, a, d, 3'b0, 3'b0, 48'h0);
    endtask

    task automatic hr(input string tag, input logic [7:0] a);
        step(tag, 1'b0, 1'b1, a, 16'h0, 3'b0, 3'b0, 48'h0);
    endtask

    task automatic push(input string tag, input logic [2:0] ps, input logic [47:0] pd);
        step(tag, 1'b0, 1'b0, 8'h0, 16'h0, 3'b0, ps, pd);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, 8'h0, 16'h0, 3'b0, 3'b0, 48'h0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < 3; n++) begin
            m_cmd[n] = 16'h0; m_rep[n] = 16'h0;
        end
        m_pend = '0; m_rdy = '0; m_cfg = '0; m_irq = 1'b0;
        rst_n = 1'b0; hst_wr = 0; hst_rd = 0; hst_addr = '0; hst_wdata = '0;
        dsp_cmd_pop = '0; dsp_rep_push = '0; dsp_rep_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        hr("R1", 8'h20); hr("R1", 8'h24); hr("R1", 8'h28); hr("R1", 8'h2C);
        hr("R1", 8'h30); hr("R1", 8'h34); hr("R1", 8'h08); hr("R1", 8'h0C);

        // R11 configuration
        hw(8'h08, 16'hA5F0); hr("R11", 8'h08);
        hw(8'h08, 16'h0000); hr("R11", 8'h08);

        // R3 command writes and readback, R5 status
        hw(8'h20, 16'h1111); hw(8'h28, 16'h2222); hw(8'h30, 16'h3333);
        hr("R3", 8'h20); hr("R3", 8'h28); hr("R3", 8'h30);
        hr("R5", 8'h0C);

        // R4 pop, pop with simultaneous write, pop of empty channel
        step("R4", 1'b0, 1'b0, 8'h0, 16'h0, 3'b001, 3'b0, 48'h0);
        hr("R4", 8'h0C); hr("R4", 8'h20);
        step("R4", 1'b1, 1'b0, 8'h20, 16'h4444, 3'b001, 3'b0, 48'h0);
        hr("R4", 8'h0C);
        step("R4", 1'b0, 1'b0, 8'h0, 16'h0, 3'b111, 3'b0, 48'h0);
        step("R4", 1'b0, 1'b0, 8'h0, 16'h0, 3'b111, 3'b0, 48'h0);
        hr("R4", 8'h0C); hr("R4", 8'h30);

        // R2 mirroring and unmapped offsets
        hw(8'h60, 16'h5555); hr("R2", 8'h20); hr("R2", 8'hE1);
        hr("R2", 8'h3C); hr("R2", 8'h1C); hr("R2", 8'h4C);
        hw(8'hA9, 16'h0123); hr("R2", 8'h28);

        // R6 reply push and status
        push("R6", 3'b011, {16'h0, 16'hBBBB, 16'hAAAA});
        hr("R6", 8'h0C);
        // R7 consume on read
        hr("R7", 8'h24); hr("R7", 8'h0C); hr("R7", 8'h24);
        // R8 overwrite of a full reply
        push("R8", 3'b010, {16'h0, 16'hCCCC, 16'h0});
        hr("R8", 8'h0C); hr("R8", 8'h2C); hr("R8", 8'h0C);
        // R7 read colliding with push
        push("R7", 3'b001, {16'h0, 16'h0, 16'h9999});
        step("R7", 1'b0, 1'b1, 8'h24, 16'h0, 3'b0, 3'b001, {16'h0, 16'h0, 16'hDDDD});
        hr("R7", 8'h0C); hr("R7", 8'h24); hr("R7", 8'h0C);

        // R9 interrupt gating
        push("R9", 3'b111, {16'h0C0C, 16'h0B0B, 16'h0A0A}); idle("R9");
        hw(8'h08, 16'h0400);
        push("R9", 3'b001, {16'h0, 16'h0, 16'h1234}); idle("R9");
        push("R9", 3'b010, {16'h0, 16'h5678, 16'h0}); idle("R9");
        push("R9", 3'b010, {16'h0, 16'h5679, 16'h0});
        push("R9", 3'b010, {16'h0, 16'h567A, 16'h0}); idle("R9");
        hw(8'h08, 16'h0E00);
        push("R9", 3'b100, {16'h7777, 16'h0, 16'h0}); idle("R9");
        push("R9", 3'b111, {16'h1, 16'h2, 16'h3}); idle("R9");
        hw(8'h08, 16'h0000);
        push("R9", 3'b111, {16'h4, 16'h5, 16'h6}); idle("R9");

        // R10 read-only and unmapped writes ignored
        hw(8'h34, 16'hFFFF); hw(8'h0C, 16'hFFFF); hw(8'h3C, 16'hFFFF);
        hr("R10", 8'h0C); hr("R10", 8'h08);
        hr("R10", 8'h34); hr("R10", 8'h2C); hr("R10", 8'h24);
        hr("R10", 8'h20); hr("R10", 8'h28); hr("R10", 8'h30);

        idle("R1"); idle("R1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule